// File: doc/BRIEF.md
# Per-Port Jabber Timer

This block guards one transmit port of a multi-port attachment-unit multiplexer against a babbling station. It watches the port's squelched activity signal and measures every packet in units of a prescaled tick. When activity lasts longer than the jabber limit, the block enters a jammed state. In that state it withdraws the port-enable, so the port's data is no longer forwarded, and it requests the collision signal on that same port's collision pair.

The jammed state ends only after the input has been idle for a full, unbroken restart interval. Any renewed activity during that interval restarts the interval from zero. A global disable input turns the protection off. While the disable is high the block never jams, and it leaves a jammed state on the next clock. A self-test (SQE) request for the port is passed through only while the port is not jammed. An active-low LED output is lit for exactly the duration of the jammed state.

The tick period and both thresholds are parameters. The defaults are a 1 µs tick from a 125 MHz clock, a 13.5 ms limit and a 500 ms restart interval. A simulation can use small values.

Top module: `jab_guard`

## Requirements
- R1: After reset, `port_en_o` is 1, `jab_col_o` is 0, `jab_led_n_o` is 1, and the length and idle measurements start from zero.
- R2: While `jab_disable_i` is 0, the block jams after the activity signal has been high through `JAB_TICKS` consecutive ticks. A tick is one clock in every `TICK_DIV`, and the first tick falls on clock `TICK_DIV` after reset. Fewer ticks do not jam the port.
- R3: A single clock with `tx_active_i` low clears the length measurement, so packets separated by any gap never add up.
- R4: In the jammed state, `port_en_o` is 0, `jab_col_o` is 1 and `jab_led_n_o` is 0. All three change on the same clock edge, one clock after the expiring tick.
- R5: A jammed port returns to the enabled state after `IDLE_TICKS` consecutive ticks with `tx_active_i` low. The three outputs return on the edge that follows the last of those ticks.
- R6: Any clock with `tx_active_i` high while the port is jammed restarts the idle interval from zero. This includes the clock of the tick that would have completed the interval.
- R7: While `jab_disable_i` is 1, the port never jams and the length measurement is held at zero. A jammed port leaves the jammed state on the first edge at which `jab_disable_i` is 1.
- R8: `sqe_ok_o` equals `sqe_req_i` while the port is enabled and is 0 while the port is jammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_active_i | input | 1 | Squelched activity on the port's transmit pair |
| jab_disable_i | input | 1 | Global disable of the jabber protection |
| sqe_req_i | input | 1 | Self-test collision request aimed at this port |
| port_en_o | output | 1 | 1 while the port's data may be forwarded |
| jab_col_o | output | 1 | Collision request for this port's own collision pair |
| jab_led_n_o | output | 1 | Active-low jabber indicator, 0 while jammed |
| sqe_ok_o | output | 1 | Self-test request after gating by the jammed state |

## Verification
Two events can fall in the same cycle. The idle interval can expire on the very tick on which activity returns, and the length limit can expire on the clock on which the disable rises. The bench provokes the first by sweeping the length of the idle gap across the expiry point, clock by clock. It provokes the second by raising the disable at several offsets around the expiring tick of a long packet. The reference model checks each case: activity wins over idle expiry and keeps the port jammed, and the disable wins over length expiry and keeps the port enabled.

// File: rtl/jab_pkg.sv
package jab_pkg;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_JAMMED = 1'b1
    } port_state_e;

    typedef struct packed {
        port_state_e st;
    } guard_regs_t;

endpackage

// File: rtl/jab_tick_gen.sv
module jab_tick_gen #(
    parameter int unsigned TICK_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV > 1) begin : g_div
            logic [PW-1:0] cnt_d, cnt_q;

            always_comb begin
                tick_o = (cnt_q == PW'(TICK_DIV - 1));
                cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            // a divided tick lasts a single clock
            assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end else begin : g_pass
            assign tick_o = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/jab_span_timer.sv
module jab_span_timer #(
    parameter int unsigned LIMIT = 13500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = !clear_i && tick_i && (cnt_q == CW'(LIMIT - 1));
        if (clear_i || expire_o) cnt_d = '0;
        else if (tick_i)         cnt_d = cnt_q + 1'b1;
        else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // count never reaches the limit itself (R2, R5)
    assert_span_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));
    // a clear leaves the count empty on the next clock (R3, R6)
    assert_span_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/jab_guard.sv
module jab_guard
    import jab_pkg::*;
#(
    parameter int unsigned TICK_DIV   = 125,
    parameter int unsigned JAB_TICKS  = 13500,
    parameter int unsigned IDLE_TICKS = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active_i,
    input  logic jab_disable_i,
    input  logic sqe_req_i,
    output logic port_en_o,
    output logic jab_col_o,
    output logic jab_led_n_o,
    output logic sqe_ok_o
);
    guard_regs_t r_d, r_q;
    logic tick, len_clear, len_expire, idle_clear, idle_expire, jammed;

    assign jammed = (r_q.st == ST_JAMMED);

    jab_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    assign len_clear  = !tx_active_i || jab_disable_i || jammed;
    assign idle_clear = tx_active_i || jab_disable_i || !jammed;

    jab_span_timer #(.LIMIT(JAB_TICKS)) u_len (
        .clk(clk), .rst_n(rst_n), .clear_i(len_clear),
        .tick_i(tick), .expire_o(len_expire)
    );

    jab_span_timer #(.LIMIT(IDLE_TICKS)) u_idle (
        .clk(clk), .rst_n(rst_n), .clear_i(idle_clear),
        .tick_i(tick), .expire_o(idle_expire)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_OPEN:   if (len_expire) r_d.st = ST_JAMMED;
            ST_JAMMED: if (jab_disable_i || idle_expire) r_d.st = ST_OPEN;
            default:   r_d.st = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_OPEN};
        else        r_q <= r_d;
    end

    assign port_en_o   = !jammed;
    assign jab_col_o   = jammed;
    assign jab_led_n_o = !jammed;
    assign sqe_ok_o    = sqe_req_i && !jammed;

    assert_jam_needs_activity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jab_col_o) |-> $past(tx_active_i && !jab_disable_i));
    assert_release_needs_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(jab_col_o) |-> $past(!tx_active_i || jab_disable_i));
    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        jab_disable_i |=> !jab_col_o);
    assert_sqe_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sqe_req_i && !port_en_o) |-> !sqe_ok_o);
endmodule

// File: tb/jab_guard_bench.sv
module jab_guard_bench;
    localparam int DIV = 4;
    localparam int JL  = 6;
    localparam int IL  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act = 1'b0, dis = 1'b0, sqe = 1'b0;
    logic port_en, jab_col, led_n, sqe_ok;

    int compared = 0, mismatched = 0, cyc = 0;
    string cur_req = "R1";

    // reference model state
    int  m_pre = 0, m_len = 0, m_idle = 0;
    bit  m_jam = 1'b0;

    always #4 clk = ~clk;

    jab_guard #(.TICK_DIV(DIV), .JAB_TICKS(JL), .IDLE_TICKS(IL)) u_jab_guard (
        .clk(clk), .rst_n(rst_n), .tx_active_i(act), .jab_disable_i(dis),
        .sqe_req_i(sqe), .port_en_o(port_en), .jab_col_o(jab_col),
        .jab_led_n_o(led_n), .sqe_ok_o(sqe_ok)
    );

    always @(posedge clk) begin
        bit t;
        cyc++;
        if (!rst_n) begin
            m_pre = 0; m_len = 0; m_idle = 0; m_jam = 1'b0;
        end else begin
            t = (m_pre == DIV - 1);
            m_pre = (m_pre + 1) % DIV;
            if (!m_jam) begin
                m_idle = 0;
                if (!act || dis) m_len = 0;
                else if (t) begin
                    m_len++;
                    if (m_len == JL) begin m_jam = 1'b1; m_len = 0; end
                end
            end else begin
                m_len = 0;
                if (dis) begin m_jam = 1'b0; m_idle = 0; end
                else if (act) m_idle = 0;
                else if (t) begin
                    m_idle++;
                    if (m_idle == IL) begin m_jam = 1'b0; m_idle = 0; end
                end
            end
        end
    end

    task automatic check(input string req, input string what, input int actual, input int expected);
        compared++;
        if (actual !== expected) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, actual, expected, cyc);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        check(cur_req, "port_en", int'(port_en), int'(!m_jam));
        check(cur_req, "jab_col", int'(jab_col), int'(m_jam));
        check(cur_req, "led_n",   int'(led_n),   int'(!m_jam));
        check(cur_req, "sqe_ok",  int'(sqe_ok),  int'(sqe && !m_jam));
    end

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    initial begin
        wait_clks(3);
        check("R1", "reset port_en", int'(port_en), 1);
        check("R1", "reset led_n", int'(led_n), 1);
        rst_n = 1'b1;

        // R2: long packet jams, check explicitly just after limit
        cur_req = "R2";
        act = 1'b1;
        wait_clks(JL * DIV + 4);
        check("R2", "jammed after long packet", int'(jab_col), 1);
        cur_req = "R4";
        check("R4", "led lit while jammed", int'(led_n), 0);

        // R8: self-test blocked while jammed
        cur_req = "R8";
        sqe = 1'b1; wait_clks(3);
        check("R8", "sqe blocked", int'(sqe_ok), 0);

        // R6: activity bursts restart the idle interval
        cur_req = "R6";
        act = 1'b0; wait_clks((IL - 2) * DIV);
        act = 1'b1; wait_clks(2);
        act = 1'b0; wait_clks((IL - 2) * DIV);
        check("R6", "still jammed after restart", int'(jab_col), 1);

        // R5: full idle releases
        cur_req = "R5";
        wait_clks(4 * DIV);
        check("R5", "released after idle", int'(port_en), 1);
        check("R8", "sqe passes when open", int'(sqe_ok), 1);
        sqe = 1'b0;

        // R3: short packets with one-clock gaps never jam
        cur_req = "R3";
        for (int k = 0; k < 5; k++) begin
            act = 1'b1; wait_clks((JL - 1) * DIV);
            act = 1'b0; wait_clks(1);
        end
        check("R3", "short packets never jam", int'(jab_col), 0);

        // R7: disable prevents jam, then releases a jammed port
        cur_req = "R7";
        dis = 1'b1; act = 1'b1; wait_clks(3 * JL * DIV);
        check("R7", "no jam while disabled", int'(jab_col), 0);
        dis = 1'b0; wait_clks(JL * DIV + 4);
        check("R7", "jam after disable lifted", int'(jab_col), 1);
        dis = 1'b1; wait_clks(1);
        check("R7", "disable releases", int'(port_en), 1);
        dis = 1'b0; act = 1'b0; wait_clks(DIV * 2);

        // same cycle: disable rising around length expiry
        cur_req = "R7";
        for (int off = -3; off <= 3; off++) begin
            act = 1'b1; wait_clks(JL * DIV - 4 + off);
            dis = 1'b1; wait_clks(2);
            dis = 1'b0; act = 1'b0; wait_clks(IL * DIV + 6);
        end

        // same cycle: activity returning around idle expiry
        cur_req = "R6";
        for (int g = IL * DIV - 4; g <= IL * DIV + 2; g++) begin
            act = 1'b1; wait_clks(JL * DIV + 4);
            act = 1'b0; wait_clks(g);
            act = 1'b1; wait_clks(1);
            act = 1'b0; wait_clks(IL * DIV + 6);
            check("R5", "open after quiet", int'(port_en), 1);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #400000;
        mismatched++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule